// File: doc/BRIEF.md
# Shift-and-Add Constant Multiplier

This block multiplies a 32-bit value by a constant without a multiplier array. The constant is given as a recipe: a short list of steps. Each step takes one scratch register, shifts it left by 0 to 3 bits, adds a second scratch register to it, and writes the sum to a third. The sequencer runs one step per clock over four scratch registers. A shift of zero with both sources the same doubles a register.

A caller pulses `start_i` with the operand, the packed recipe and the step count. Scratch register 0 takes the operand and the other registers clear. The steps then run in order. When the last step has run, the product and an overflow flag are registered and `done_o` pulses for one cycle. For example, 120·v takes three steps: 5v = 4v+v, then 15v = 2·5v+5v, then 120v = 8·15v+0.

Top module: `shadd_cmul`

## Requirements
- R1: While reset is held low, and in the cycle after it is released, `busy_o`, `done_o` and `ovf_o` are 0 and `product_o` is 0.
- R2: A step is one byte: bits [1:0] give the shift amount s, bits [3:2] give source A, bits [5:4] give source B, and bits [7:6] give the destination. Step i sits at `recipe_i[8i+7:8i]`. A step writes (A << s) + B, modulo 2^32, into the destination register.
- R3: A start that is accepted sets scratch register 0 to `operand_i` and clears registers 1 to 3. It captures `recipe_i` and `len_i`, and the run has `len_i`+1 steps. The steps run in index order, and a later step sees the writes of earlier steps.
- R4: The rising edge that accepts a start is edge 1. `busy_o` is 1 from edge 1 up to edge `len_i`+2. `done_o` is 1 for exactly one cycle, beginning at edge `len_i`+2, and `busy_o` is 0 in that cycle.
- R5: `product_o` takes the value written by the final step in the same cycle that `done_o` rises. It holds that value, unchanged, until the next run completes.
- R6: `ovf_o`, updated together with `product_o`, is 1 when at least one step of the run had an exact result of 2^32 or more. This includes bits lost by the shift alone.
- R7: A start that arrives while `busy_o` is 1 is ignored. The running sequence, its captured recipe and its result are unaffected.
- R8: A start in the cycle where `done_o` is 1 is accepted and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| operand_i | input | 32 | Value to multiply, captured at start |
| recipe_i | input | 64 | Eight packed steps, step i in byte i |
| len_i | input | 3 | Number of steps minus one |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 32 | Result of the final step, held |
| ovf_o | output | 1 | Some step of the last run lost bits above bit 31 |

## Verification
The checker watches every cycle for the following:
- `done_o` stays one cycle wide, and it follows a busy period.
- `busy_o` only rises after a start.
- While a run is in progress, the step index advances by exactly one per cycle and never passes the captured length, even when start is raised.
- The captured length stays fixed for the whole run.
- `product_o` and `ovf_o` change only together with `done_o`.

Only the bench's scenarios can show the following:
- The arithmetic of each step, the byte layout of the recipe, and the order of the steps.
- The exact completion cycle.
- That a start raised during a run leaves the result unchanged.

To cover these, the bench compares the results with products and overflow that it computes itself. It sweeps every single-step encoding over boundary operands, and it also runs the 120 recipe and pseudo-random multi-step recipes.

// File: rtl/shadd_pkg.sv
package shadd_pkg;
  localparam int DATA_W    = 32;
  localparam int NREG      = 4;
  localparam int MAX_STEPS = 8;
  localparam int SH_W      = 2;
  localparam int IDX_W     = $clog2(NREG);
  localparam int CNT_W     = $clog2(MAX_STEPS);
  localparam int STEP_W    = SH_W + 3 * IDX_W;
  localparam int RECIPE_W  = STEP_W * MAX_STEPS;
  localparam int SH_MAX    = (1 << SH_W) - 1;
  localparam int WIDE_W    = DATA_W + SH_MAX + 1;

  typedef struct packed {
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] src_b;
    logic [IDX_W-1:0] src_a;
    logic [SH_W-1:0]  shamt;
  } step_t;
endpackage

// File: rtl/shadd_alu.sv
module shadd_alu
  import shadd_pkg::*;
(
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [SH_W-1:0]   shamt_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              ovf_o
);
  logic [WIDE_W-1:0] wide_a;
  logic [WIDE_W-1:0] wide_sum;

  always_comb begin
    wide_a   = {{(WIDE_W-DATA_W){1'b0}}, opa_i} << shamt_i;
    wide_sum = wide_a + {{(WIDE_W-DATA_W){1'b0}}, opb_i};
    sum_o    = wide_sum[DATA_W-1:0];
    ovf_o    = |wide_sum[WIDE_W-1:DATA_W];
  end
endmodule

// File: rtl/shadd_regfile.sv
module shadd_regfile
  import shadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic [DATA_W-1:0] init_val_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_a_i,
  input  logic [IDX_W-1:0]  raddr_b_i,
  input  logic [IDX_W-1:0]  raddr_c_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o,
  output logic [DATA_W-1:0] rdata_c_o
);
  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic              en;
    logic [DATA_W-1:0] nxt;

    always_comb begin
      en  = init_i || (we_i && (waddr_i == IDX_W'(g)));
      if (init_i) nxt = (g == 0) ? init_val_i : '0;
      else        nxt = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs[g] <= '0;
      else if (en) regs[g] <= nxt;
    end
  end

  always_comb begin
    rdata_a_o = regs[raddr_a_i];
    rdata_b_o = regs[raddr_b_i];
    rdata_c_o = regs[raddr_c_i];
  end
endmodule

// File: rtl/shadd_seq.sv
module shadd_seq
  import shadd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [RECIPE_W-1:0] recipe_i,
  input  logic [CNT_W-1:0]    len_i,
  output logic                accept_o,
  output logic                busy_o,
  output logic                last_o,
  output logic                done_o,
  output logic [CNT_W-1:0]    idx_o,
  output logic [CNT_W-1:0]    len_o,
  output step_t               step_o
);
  logic                busy_q, busy_d;
  logic                done_q, done_d;
  logic [CNT_W-1:0]    idx_q, idx_d;
  logic [CNT_W-1:0]    len_q;
  logic [RECIPE_W-1:0] recipe_q;
  logic                accept;
  logic                last;

  always_comb begin
    accept = start_i && !busy_q;
    last   = busy_q && (idx_q == len_q);
    busy_d = busy_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q    <= '0;
      recipe_q <= '0;
    end else if (accept) begin
      len_q    <= len_i;
      recipe_q <= recipe_i;
    end
  end

  always_comb begin
    step_o   = step_t'(recipe_q[idx_q*STEP_W +: STEP_W]);
    accept_o = accept;
    busy_o   = busy_q;
    last_o   = last;
    done_o   = done_q;
    idx_o    = idx_q;
    len_o    = len_q;
  end
endmodule

// File: rtl/shadd_cmul.sv
module shadd_cmul
  import shadd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [DATA_W-1:0]   operand_i,
  input  logic [RECIPE_W-1:0] recipe_i,
  input  logic [CNT_W-1:0]    len_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [DATA_W-1:0]   product_o,
  output logic                ovf_o
);
  logic              accept;
  logic              busy;
  logic              last;
  logic              done;
  logic [CNT_W-1:0]  step_idx;
  logic [CNT_W-1:0]  len_q;
  step_t             step;
  logic [DATA_W-1:0] opa, opb, unused_c;
  logic [DATA_W-1:0] sum;
  logic              step_ovf;
  logic              ovf_acc_q, ovf_acc_d;
  logic [DATA_W-1:0] product_q;
  logic              ovf_q;

  shadd_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .recipe_i (recipe_i),
    .len_i    (len_i),
    .accept_o (accept),
    .busy_o   (busy),
    .last_o   (last),
    .done_o   (done),
    .idx_o    (step_idx),
    .len_o    (len_q),
    .step_o   (step)
  );

  shadd_regfile u_rf (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (accept),
    .init_val_i (operand_i),
    .we_i       (busy),
    .waddr_i    (step.dst),
    .wdata_i    (sum),
    .raddr_a_i  (step.src_a),
    .raddr_b_i  (step.src_b),
    .raddr_c_i  (step.dst),
    .rdata_a_o  (opa),
    .rdata_b_o  (opb),
    .rdata_c_o  (unused_c)
  );

  shadd_alu u_alu (
    .opa_i   (opa),
    .opb_i   (opb),
    .shamt_i (step.shamt),
    .sum_o   (sum),
    .ovf_o   (step_ovf)
  );

  always_comb begin
    ovf_acc_d = ovf_acc_q;
    if (accept)    ovf_acc_d = 1'b0;
    else if (busy) ovf_acc_d = ovf_acc_q | step_ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_acc_q <= 1'b0;
    else        ovf_acc_q <= ovf_acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      product_q <= '0;
      ovf_q     <= 1'b0;
    end else if (last) begin
      product_q <= sum;
      ovf_q     <= ovf_acc_q | step_ovf;
    end
  end

  always_comb begin
    busy_o    = busy;
    done_o    = done;
    product_o = product_q;
    ovf_o     = ovf_q;
  end
endmodule

// File: rtl/shadd_cmul_chk.sv
module shadd_cmul_chk
  import shadd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] product_o,
  input logic              ovf_o,
  input logic [CNT_W-1:0]  step_idx,
  input logic [CNT_W-1:0]  len_q
);
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_busy_needs_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (step_idx <= len_q));

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && (step_idx != len_q)) |=>
      (busy_o && (step_idx == CNT_W'($past(step_idx) + CNT_W'(1)))));

  assert_len_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(len_q));

  assert_product_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(product_o) |-> done_o);

  assert_ovf_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ovf_o) |-> done_o);
endmodule

bind shadd_cmul shadd_cmul_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .product_o (product_o),
  .ovf_o     (ovf_o),
  .step_idx  (step_idx),
  .len_q     (len_q)
);

// File: tb/shadd_cmul_bench.sv
`timescale 1ns/1ps
module shadd_cmul_bench;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] operand_i;
  logic [63:0] recipe_i;
  logic [2:0]  len_i;
  logic        busy_o;
  logic        done_o;
  logic [31:0] product_o;
  logic        ovf_o;

  int vectors;
  int errors;
  logic [31:0] rng;

  shadd_cmul u_shadd_cmul (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .operand_i (operand_i),
    .recipe_i  (recipe_i),
    .len_i     (len_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o),
    .ovf_o     (ovf_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // Reference: R2 step layout and arithmetic, R3 init and order, R6 overflow
  task automatic model(input logic [31:0] op, input logic [63:0] rec, input logic [2:0] len,
                       output logic [31:0] prod, output logic ovf);
    logic [31:0] r [4];
    logic [63:0] full;
    logic [7:0]  st;
    r[0] = op; r[1] = 0; r[2] = 0; r[3] = 0;
    ovf  = 1'b0;
    prod = 0;
    for (int i = 0; i <= int'(len); i++) begin
      st   = rec[i*8 +: 8];
      full = ({32'd0, r[st[3:2]]} << st[1:0]) + {32'd0, r[st[5:4]]};
      if (full[63:32] != 0) ovf = 1'b1;
      r[st[7:6]] = full[31:0];
      prod = full[31:0];
    end
  endtask

  // Called just after a negedge. Returns just after the negedge of the done cycle.
  task automatic run(input logic [31:0] op, input logic [63:0] rec, input logic [2:0] len,
                     input bit inject, input string tag);
    logic [31:0] ep;
    logic        eo;
    model(op, rec, len, ep, eo);
    operand_i = op; recipe_i = rec; len_i = len; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    check({tag, " R4 busy after start"}, {63'd0, busy_o}, 64'd1);
    for (int k = 1; k <= int'(len); k++) begin
      @(posedge clk);
      @(negedge clk);
      check({tag, " R4 no early done"}, {63'd0, done_o}, 64'd0);
      start_i = 1'b0;
      if (inject && k == 1) begin
        start_i   = 1'b1;
        operand_i = ~op;
        recipe_i  = ~rec;
        len_i     = ~len;
      end
    end
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    check({tag, " R4 done pulse"}, {63'd0, done_o}, 64'd1);
    check({tag, " R4 busy low at done"}, {63'd0, busy_o}, 64'd0);
    check({tag, " R5 product"}, {32'd0, product_o}, {32'd0, ep});
    check({tag, " R6 overflow"}, {63'd0, ovf_o}, {63'd0, eo});
  endtask

  task automatic check_hold(input logic [31:0] ep, input logic eo);
    @(posedge clk);
    @(negedge clk);
    check("R4 done one cycle", {63'd0, done_o}, 64'd0);
    check("R5 product held", {32'd0, product_o}, {32'd0, ep});
    check("R6 overflow held", {63'd0, ovf_o}, {63'd0, eo});
  endtask

  initial begin : watchdog
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] ep;
    logic        eo;
    logic [63:0] rec;
    logic [31:0] op;
    vectors = 0; errors = 0;
    rng = 32'h1234_5678;
    rst_n = 1'b0; start_i = 1'b0; operand_i = 0; recipe_i = 0; len_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 busy in reset", {63'd0, busy_o}, 64'd0);
    check("R1 done in reset", {63'd0, done_o}, 64'd0);
    check("R1 product in reset", {32'd0, product_o}, 64'd0);
    check("R1 ovf in reset", {63'd0, ovf_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {61'd0, busy_o, done_o, ovf_o}, 64'd0);
    check("R1 product after reset", {32'd0, product_o}, 64'd0);

    // R3 R2: 120 recipe: R1=4R0+R0, R2=2R1+R1, R3=8R2+R3
    rec = {40'd0, 2'd3, 2'd3, 2'd2, 2'd3, 2'd2, 2'd1, 2'd1, 2'd1, 2'd1, 2'd0, 2'd0, 2'd2};
    foreach (op[i]) begin
      run(32'd1 << i, rec, 3'd2, 1'b0, "x120");
    end
    run(32'd12, rec, 3'd2, 1'b0, "x120");
    check("R2 120x12", {32'd0, product_o}, 64'd1440);
    run(32'hFFFF_FFFF, rec, 3'd2, 1'b0, "x120 ovf");
    check("R6 all ones ovf", {63'd0, ovf_o}, 64'd1);
    check_hold(32'hFFFF_FFFF * 32'd120, 1'b1);

    // R2: every single-step encoding over boundary operands
    for (int e = 0; e < 256; e++) begin
      for (int v = 0; v < 3; v++) begin
        op = (v == 0) ? 32'h8000_0001 : (v == 1) ? 32'h1FFF_FFFF : rng;
        rng = next_rand(rng);
        @(negedge clk);
        run(op, {56'd0, 8'(e)}, 3'd0, 1'b0, "R2 single");
      end
    end

    // R6: lost bit from shift alone, plain add, then clean run clears flag
    @(negedge clk);
    run(32'h8000_0000, {56'd0, 2'd1, 2'd1, 2'd0, 2'd1}, 3'd0, 1'b0, "R6 shift loss");
    check("R6 shift loss flag", {63'd0, ovf_o}, 64'd1);
    run(32'h0000_0003, {56'd0, 2'd1, 2'd1, 2'd0, 2'd1}, 3'd0, 1'b0, "R6 clean");
    check("R6 cleared on next run", {63'd0, ovf_o}, 64'd0);

    // R8: back-to-back starts in the done cycle; R3/R2 random multi-step recipes
    for (int t = 0; t < 400; t++) begin
      rec = {rng, next_rand(rng)};
      rng = next_rand(next_rand(rng));
      op  = rng;
      rng = next_rand(rng);
      run(op, rec, rng[2:0], 1'b0, "R8 back-to-back");
      rng = next_rand(rng);
    end

    // R7: start raised during a run is ignored
    for (int t = 0; t < 100; t++) begin
      rec = {rng, next_rand(rng)};
      rng = next_rand(next_rand(rng));
      op  = rng;
      rng = next_rand(rng);
      @(negedge clk);
      run(op, rec, 3'(1 + (t % 7)), 1'b1, "R7 start ignored");
      model(op, rec, 3'(1 + (t % 7)), ep, eo);
      check_hold(ep, eo);
    end

    // R3: full eight-step doubling chain
    @(negedge clk);
    run(32'd5, {8{2'd0, 2'd0, 2'd0, 2'd0}}, 3'd7, 1'b0, "R3 eight doublings");
    check("R3 5*256", {32'd0, product_o}, 64'd1280);
    check_hold(32'd1280, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule